// File: doc/BRIEF.md
# AUX Channel Native Transfer Sequencer

This block takes a host request for a native register read or write of any byte length on a sideband auxiliary channel. It turns that request into a series of channel transactions. The request is cut into pieces of at most sixteen bytes. For each piece the block programs a command word, a 20-bit target address and a 16-entry channel data buffer. It then starts the channel and classifies the outcome. A failed piece is retried from a clean buffer. Only a successful piece moves the transfer forward.

On the host side a request is a start pulse with a 20-bit address, a byte count and a direction. Write bytes are pulled from the host with a valid/ready handshake. Read bytes are pushed back as a valid-qualified stream. The channel side is a set of pulses (buffer clear, address load, buffer write, go) and a completion input that carries a reply strobe, an error flag and a 4-bit status field. An enable-busy input stays high until the channel has taken the command.

Top module: `aux_xfer_seq`

## Requirements
- R1: A request of N bytes runs as ceil(N/16) pieces of 16 bytes each, except the last, which carries N mod 16 bytes when that is nonzero. Each piece starts at the request address plus the byte count of all earlier successful pieces.
- R2: A piece is attempted at most 10 times. If all 10 attempts fail, the block raises `err` for one cycle, does not raise `done`, and issues no further attempts.
- R3: Every attempt begins with one cycle of `ch_buf_clr`, followed in the next cycle by `ch_addr_we`. The address fields are `ch_addr_lo` = address bits 7:0, `ch_addr_mid` = bits 15:8 and `ch_addr_hi` = bits 19:16.
- R4: In the cycle of `ch_go`, the command word `ch_cmd` has bit 3 set (native transaction), bit 0 = 1 for read and 0 for write, bits 7:4 = piece length minus one, and bits 2:1 = 0.
- R5: For a write, each host byte is taken exactly once, in order. Before `ch_go`, the piece's bytes are written to channel buffer indices 0 up to length-1. A retry reloads them from an internal copy without pulling from the host again.
- R6: For a read, the channel buffer entries 0 up to length-1 are emitted on `rdata` in index order, and only after an attempt has succeeded. Failed attempts emit nothing.
- R7: An attempt fails if `ch_en_busy` is still high EN_TIMEOUT cycles after `ch_go`.
- R8: An attempt fails if no `ch_reply` arrives within RP_TIMEOUT cycles after `ch_en_busy` falls.
- R9: An attempt fails if `ch_reply` arrives with `ch_err` high or with a nonzero `ch_status`.
- R10: `busy` is high from the cycle after an accepted nonzero-length start until completion. `done` and `err` are single-cycle pulses, never both high, and are raised with `busy` low.
- R11: A start with a length of zero raises `done` in the next cycle, with no channel activity and without raising `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 20 | Start address of the transfer |
| req_len | input | 16 | Byte count of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Host write byte |
| wdata_valid | input | 1 | Host write byte available |
| wdata_ready | output | 1 | Block takes `wdata` this cycle |
| rdata | output | 8 | Read byte to host |
| rdata_valid | output | 1 | `rdata` holds a byte this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed successfully (pulse) |
| err | output | 1 | Transfer abandoned after exhausted retries (pulse) |
| ch_cmd | output | 8 | Command word for the channel |
| ch_addr_lo | output | 8 | Address bits 7:0 |
| ch_addr_mid | output | 8 | Address bits 15:8 |
| ch_addr_hi | output | 4 | Address bits 19:16 |
| ch_addr_we | output | 1 | Address fields being loaded |
| ch_buf_clr | output | 1 | Clear the channel data buffer |
| ch_buf_we | output | 1 | Write `ch_buf_wdata` at `ch_buf_idx` |
| ch_buf_idx | output | 4 | Channel buffer index for write or read |
| ch_buf_wdata | output | 8 | Byte written to the channel buffer |
| ch_buf_rdata | input | 8 | Channel buffer entry at `ch_buf_idx` |
| ch_go | output | 1 | Start the channel transaction |
| ch_en_busy | input | 1 | Channel has not yet taken the command |
| ch_reply | input | 1 | Reply received strobe |
| ch_err | input | 1 | Access error flag, valid with `ch_reply` |
| ch_status | input | 4 | Reply status, nonzero means failure |

## Verification
A wrong piece length or a premature address step shows at the next `ch_go`. In that same cycle the command length field or the address fields disagree with the bench's running expectation. A miscounted retry counter shows as the wrong number of `ch_go` pulses before `done` or `err`, which is visible within ten attempts. A broken copy-back path or write reload shows as wrong bytes in the read stream within a few cycles of the reply, or as wrong buffer contents captured at the retried `ch_go`. Buffer state that is not cleared between attempts shows because every attempt must start with its clear and address-load pulses.

// File: rtl/aux_seq_pkg.sv
// Package: shared state encoding and command word builder for the
// AUX transfer sequencer. Assumes pieces of at most 16 bytes, so that
// the length minus one fits the 4-bit command length field.
package aux_seq_pkg;

    localparam int CMD_W          = 8;
    localparam int CMD_NATIVE_BIT = 3;
    localparam int CMD_READ_BIT   = 0;
    localparam int CMD_LEN_LSB    = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHUNK,
        S_FILL,
        S_CLR,
        S_ADDR,
        S_LOAD,
        S_GO,
        S_WAIT_EN,
        S_WAIT_RP,
        S_FAIL,
        S_COPY,
        S_ADV
    } seq_state_t;

    // Build the channel command word from the direction and the piece length (1..16).
    function automatic logic [CMD_W-1:0] make_cmd(input logic is_read, input logic [4:0] plen);
        logic [CMD_W-1:0] w;
        logic [4:0]       lm1;
        w   = '0;
        lm1 = plen - 5'd1;
        w[CMD_NATIVE_BIT] = 1'b1;
        w[CMD_READ_BIT]   = is_read;
        w[CMD_LEN_LSB +: 4] = lm1[3:0];
        return w;
    endfunction

endpackage

// File: rtl/aux_wait_timer.sv
// Module: aux_wait_timer
// Counts the consecutive cycles for which `run` is high and flags
// `expired` in the cycle where that count reaches LIMIT. Any cycle with
// `run` low restarts the count. Assumes LIMIT >= 1.
module aux_wait_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    // Count the cycles of the current wait and restart when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end else begin
            cnt <= '0;
        end
    end

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/aux_chunk_buf.sv
// Module: aux_chunk_buf
// Small register file that holds one piece of write data, so that a
// retried attempt can reload the channel buffer without asking the host
// again. One synchronous write port and one combinational read port.
module aux_chunk_buf #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Hold the piece bytes; each entry is written once per piece.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (we && (waddr == g)) begin
                    mem[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem[raddr];

endmodule

// File: rtl/aux_xfer_seq.sv
// Module: aux_xfer_seq
// Splits a native AUX read or write into pieces of at most CHUNK bytes
// and runs each piece as a channel transaction. A piece is retried up
// to MAX_TRIES times. An attempt fails on an enable timeout, a reply
// timeout, a reply error flag or a nonzero reply status. Address and
// host byte position advance only after a successful piece.
// Assumes the channel keeps ch_buf_rdata combinational on ch_buf_idx
// and that ch_err / ch_status are valid in the cycle of ch_reply.
module aux_xfer_seq
    import aux_seq_pkg::*;
#(
    parameter int CHUNK      = 16,
    parameter int MAX_TRIES  = 10,
    parameter int LEN_W      = 16,
    parameter int EN_TIMEOUT = 2000,
    parameter int RP_TIMEOUT = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [19:0] req_addr,
    input  logic [15:0] req_len,
    input  logic        req_write,
    input  logic [7:0]  wdata,
    input  logic        wdata_valid,
    output logic        wdata_ready,
    output logic [7:0]  rdata,
    output logic        rdata_valid,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  ch_cmd,
    output logic [7:0]  ch_addr_lo,
    output logic [7:0]  ch_addr_mid,
    output logic [3:0]  ch_addr_hi,
    output logic        ch_addr_we,
    output logic        ch_buf_clr,
    output logic        ch_buf_we,
    output logic [3:0]  ch_buf_idx,
    output logic [7:0]  ch_buf_wdata,
    input  logic [7:0]  ch_buf_rdata,
    output logic        ch_go,
    input  logic        ch_en_busy,
    input  logic        ch_reply,
    input  logic        ch_err,
    input  logic [3:0]  ch_status
);
    localparam int ADDR_W = 20;
    localparam int IDX_W  = $clog2(CHUNK);
    localparam int CLEN_W = $clog2(CHUNK + 1);
    localparam int TRY_W  = $clog2(MAX_TRIES);

    seq_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [CLEN_W-1:0] clen;
    logic [CLEN_W-1:0] bcnt;
    logic [TRY_W-1:0]  tries;
    logic              is_rd;
    logic              done_q;
    logic              err_q;
    logic [7:0]        rdata_q;
    logic              rdv_q;
    logic [7:0]        addr_lo_q;
    logic [7:0]        addr_mid_q;
    logic [3:0]        addr_hi_q;

    logic              last_byte;
    logic [CLEN_W-1:0] next_clen;
    logic              en_exp;
    logic              rp_exp;
    logic              reply_bad;
    logic              st_we;
    logic [7:0]        st_rdata;

    // Length of the next piece: a full piece or whatever remains.
    always_comb begin
        if (remain >= LEN_W'(CHUNK)) begin
            next_clen = CLEN_W'(CHUNK);
        end else begin
            next_clen = remain[CLEN_W-1:0];
        end
    end

    assign last_byte = (bcnt == clen - CLEN_W'(1));
    assign reply_bad = ch_err || (ch_status != 4'd0);
    assign st_we     = (state == S_FILL) && wdata_valid;

    aux_wait_timer #(.LIMIT(EN_TIMEOUT)) u_en_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_WAIT_EN),
        .expired (en_exp)
    );

    aux_wait_timer #(.LIMIT(RP_TIMEOUT)) u_rp_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_WAIT_RP),
        .expired (rp_exp)
    );

    aux_chunk_buf #(.DEPTH(CHUNK), .DATA_W(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (bcnt[IDX_W-1:0]),
        .wdata (wdata),
        .raddr (bcnt[IDX_W-1:0]),
        .rdata (st_rdata)
    );

    // Sequencer: piece setup, attempt steps, outcome classification and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            clen     <= '0;
            bcnt     <= '0;
            tries    <= '0;
            is_rd    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
            rdv_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rdv_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        if (req_len == 16'd0) begin
                            done_q <= 1'b1;
                        end else begin
                            cur_addr <= req_addr;
                            remain   <= LEN_W'(req_len);
                            is_rd    <= !req_write;
                            state    <= S_CHUNK;
                        end
                    end
                end
                S_CHUNK: begin
                    clen  <= next_clen;
                    tries <= '0;
                    bcnt  <= '0;
                    state <= is_rd ? S_CLR : S_FILL;
                end
                S_FILL: begin
                    if (wdata_valid) begin
                        if (last_byte) begin
                            bcnt  <= '0;
                            state <= S_CLR;
                        end else begin
                            bcnt <= bcnt + CLEN_W'(1);
                        end
                    end
                end
                S_CLR: begin
                    bcnt  <= '0;
                    state <= S_ADDR;
                end
                S_ADDR: begin
                    state <= is_rd ? S_GO : S_LOAD;
                end
                S_LOAD: begin
                    if (last_byte) begin
                        bcnt  <= '0;
                        state <= S_GO;
                    end else begin
                        bcnt <= bcnt + CLEN_W'(1);
                    end
                end
                S_GO: begin
                    state <= S_WAIT_EN;
                end
                S_WAIT_EN: begin
                    if (!ch_en_busy) begin
                        state <= S_WAIT_RP;
                    end else if (en_exp) begin
                        state <= S_FAIL;
                    end
                end
                S_WAIT_RP: begin
                    if (ch_reply) begin
                        if (reply_bad) begin
                            state <= S_FAIL;
                        end else if (is_rd) begin
                            bcnt  <= '0;
                            state <= S_COPY;
                        end else begin
                            state <= S_ADV;
                        end
                    end else if (rp_exp) begin
                        state <= S_FAIL;
                    end
                end
                S_FAIL: begin
                    if (tries == TRY_W'(MAX_TRIES - 1)) begin
                        err_q <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        tries <= tries + TRY_W'(1);
                        state <= S_CLR;
                    end
                end
                S_COPY: begin
                    rdata_q <= ch_buf_rdata;
                    rdv_q   <= 1'b1;
                    if (last_byte) begin
                        bcnt  <= '0;
                        state <= S_ADV;
                    end else begin
                        bcnt <= bcnt + CLEN_W'(1);
                    end
                end
                S_ADV: begin
                    cur_addr <= cur_addr + ADDR_W'(clen);
                    remain   <= remain - LEN_W'(clen);
                    if (remain == LEN_W'(clen)) begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        state <= S_CHUNK;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Address field registers, loaded in the address step of each attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q  <= '0;
            addr_mid_q <= '0;
            addr_hi_q  <= '0;
        end else if (state == S_ADDR) begin
            addr_lo_q  <= cur_addr[7:0];
            addr_mid_q <= cur_addr[15:8];
            addr_hi_q  <= cur_addr[19:16];
        end
    end

    assign busy         = (state != S_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign wdata_ready  = (state == S_FILL);
    assign rdata        = rdata_q;
    assign rdata_valid  = rdv_q;
    assign ch_cmd       = make_cmd(is_rd, clen);
    assign ch_addr_lo   = addr_lo_q;
    assign ch_addr_mid  = addr_mid_q;
    assign ch_addr_hi   = addr_hi_q;
    assign ch_addr_we   = (state == S_ADDR);
    assign ch_buf_clr   = (state == S_CLR);
    assign ch_buf_we    = (state == S_LOAD);
    assign ch_buf_idx   = bcnt[IDX_W-1:0];
    assign ch_buf_wdata = st_rdata;
    assign ch_go        = (state == S_GO);

endmodule

// File: rtl/aux_xfer_seq_chk.sv
// Module: aux_xfer_seq_chk
// Port-level protocol checks for aux_xfer_seq, bound to every instance.
module aux_xfer_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] req_len,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        wdata_ready,
    input logic        rdata_valid,
    input logic [7:0]  ch_cmd,
    input logic        ch_addr_we,
    input logic        ch_buf_clr,
    input logic        ch_buf_we,
    input logic        ch_go
);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r2_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_len != 16'd0) |=> busy);

    a_r11_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_len == 16'd0) |=> (done && !busy));

    a_r3_clear_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ch_buf_clr |=> ch_addr_we);

    a_r4_native_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ch_go |-> (ch_cmd[3] && ch_cmd[2:1] == 2'b00));

    a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        ch_go |=> !ch_go);

    a_r5_pull_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_ready |-> (busy && !ch_buf_we && !ch_go));

    a_r6_rdata_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> busy);

endmodule

bind aux_xfer_seq aux_xfer_seq_chk u_chk (.*);

// File: tb/aux_xfer_seq_bench.sv
// Bench: directed scenarios against a behavioural channel model.
module aux_xfer_seq_bench;

    localparam int EN_TO = 8;
    localparam int RP_TO = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_write = 1'b0;
    logic [7:0]  wdata;
    logic        wdata_valid;
    logic        wdata_ready;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic        busy, done, err;
    logic [7:0]  ch_cmd, ch_addr_lo, ch_addr_mid;
    logic [3:0]  ch_addr_hi;
    logic        ch_addr_we, ch_buf_clr, ch_buf_we, ch_go;
    logic [3:0]  ch_buf_idx;
    logic [7:0]  ch_buf_wdata, ch_buf_rdata;
    logic        ch_en_busy = 1'b0;
    logic        ch_reply = 1'b0;
    logic        ch_err = 1'b0;
    logic [3:0]  ch_status = 4'd0;

    always #5 clk = ~clk;

    aux_xfer_seq #(.EN_TIMEOUT(EN_TO), .RP_TIMEOUT(RP_TO)) u_aux_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .wdata(wdata),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .rdata(rdata),
        .rdata_valid(rdata_valid), .busy(busy), .done(done), .err(err),
        .ch_cmd(ch_cmd), .ch_addr_lo(ch_addr_lo), .ch_addr_mid(ch_addr_mid),
        .ch_addr_hi(ch_addr_hi), .ch_addr_we(ch_addr_we), .ch_buf_clr(ch_buf_clr),
        .ch_buf_we(ch_buf_we), .ch_buf_idx(ch_buf_idx), .ch_buf_wdata(ch_buf_wdata),
        .ch_buf_rdata(ch_buf_rdata), .ch_go(ch_go), .ch_en_busy(ch_en_busy),
        .ch_reply(ch_reply), .ch_err(ch_err), .ch_status(ch_status)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Scenario configuration and records kept by the channel model.
    int        fails_left = 0;
    int        fail_mode  = 0;   // 0 err flag, 1 status, 2 no reply, 3 enable stuck
    bit        cur_fail   = 0;
    int        go_cnt = 0, clr_cnt = 0, seq_bad = 0, cmd_bad = 0, wbuf_bad = 0;
    bit        saw_clr = 0, saw_addr = 0;
    logic [19:0] go_addr [32];
    int        go_len  [32];
    bit        go_rd   [32];
    logic [7:0] chmem  [16];
    int        en_cnt = 0, rp_cnt = 0;
    bit        rp_pend = 0;
    logic [19:0] xfer_base = '0;

    // Host byte source and read sink.
    logic [7:0] wsrc [64];
    int         widx = 0;
    bit         wr_active = 0;
    logic [7:0] rcv [64];
    int         rcnt = 0;

    assign wdata_valid  = wr_active;
    assign wdata        = wsrc[widx % 64];
    assign ch_buf_rdata = chmem[ch_buf_idx];

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h5, a[19:16]};
    endfunction

    // Host stream side: count pulled bytes and collect read bytes.
    always @(posedge clk) begin
        if (wdata_valid && wdata_ready) widx <= widx + 1;
        if (rdata_valid) begin
            if (rcnt < 64) rcv[rcnt] <= rdata;
            rcnt <= rcnt + 1;
        end
    end

    // Channel model: buffer, enable handshake, reply with configured failures.
    always @(posedge clk) begin
        ch_reply <= 1'b0;
        if (ch_buf_clr) begin
            for (int i = 0; i < 16; i++) chmem[i] <= 8'h00;
            ch_en_busy <= 1'b0;
            rp_pend    <= 1'b0;
            clr_cnt    = clr_cnt + 1;
            saw_clr    = 1;
            saw_addr   = 0;
        end else if (ch_buf_we) begin
            chmem[ch_buf_idx] <= ch_buf_wdata;
        end
        if (ch_addr_we) begin
            if (!saw_clr) seq_bad = seq_bad + 1;
            saw_addr = 1;
        end
        if (ch_go) begin
            logic [19:0] a;
            int          ln;
            a  = {ch_addr_hi, ch_addr_mid, ch_addr_lo};
            ln = int'(ch_cmd[7:4]) + 1;
            if (!saw_addr || !ch_cmd[3] || ch_cmd[2:1] != 2'b00) cmd_bad = cmd_bad + 1;
            if (go_cnt < 32) begin
                go_addr[go_cnt] = a;
                go_len[go_cnt]  = ln;
                go_rd[go_cnt]   = ch_cmd[0];
            end
            go_cnt = go_cnt + 1;
            saw_clr  = 0;
            saw_addr = 0;
            if (!ch_cmd[0]) begin
                for (int i = 0; i < ln; i++)
                    if (chmem[i] != wsrc[(int'(a - xfer_base) + i) % 64]) wbuf_bad = wbuf_bad + 1;
            end else begin
                for (int i = 0; i < 16; i++)
                    chmem[i] <= (i < ln) ? pat(a + 20'(i)) : 8'hEE;
            end
            cur_fail = (fails_left > 0);
            if (fails_left > 0) fails_left = fails_left - 1;
            ch_en_busy <= 1'b1;
            en_cnt     <= (cur_fail && fail_mode == 3) ? 100000 : 2;
        end else if (ch_en_busy && !ch_buf_clr) begin
            if (en_cnt == 0) begin
                ch_en_busy <= 1'b0;
                rp_pend    <= !(cur_fail && fail_mode == 2);
                rp_cnt     <= 2;
            end else begin
                en_cnt <= en_cnt - 1;
            end
        end else if (rp_pend && !ch_buf_clr) begin
            if (rp_cnt == 0) begin
                ch_reply  <= 1'b1;
                ch_err    <= cur_fail && fail_mode == 0;
                ch_status <= (cur_fail && fail_mode == 1) ? 4'h2 : 4'h0;
                rp_pend   <= 1'b0;
            end else begin
                rp_cnt <= rp_cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    bit got_done, got_err, busy_seen;

    task automatic run_xfer(input logic [19:0] a, input int len, input bit wr,
                            input int nf, input int mode);
        bit fin;
        @(negedge clk);
        go_cnt = 0; clr_cnt = 0; seq_bad = 0; cmd_bad = 0; wbuf_bad = 0;
        saw_clr = 0; saw_addr = 0;
        fails_left = nf; fail_mode = mode;
        rcnt = 0; widx = 0; xfer_base = a;
        for (int i = 0; i < 64; i++) wsrc[i] = 8'h3C ^ 8'(i * 7);
        wr_active = wr;
        req_addr = a; req_len = 16'(len); req_write = wr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_seen = busy;
        got_done = 0; got_err = 0; fin = 0;
        for (int c = 0; c < 5000 && !fin; c++) begin
            if (done || err) begin
                got_done = done; got_err = err; fin = 1;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        wr_active = 0;
    endtask

    task automatic check_read_bytes(input string req, input logic [19:0] a, input int len);
        int bad = 0;
        for (int i = 0; i < len && i < 64; i++)
            if (rcv[i] != pat(a + 20'(i))) bad++;
        check(rcnt == len, req, rcnt, len);
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !err && !ch_go && !wdata_ready, "R10 reset idle",
              {busy, done, err, ch_go}, 0);
    endtask

    task automatic t_read_chunks();
        // R1: 37 bytes cross a 64K boundary -> pieces 16,16,5
        run_xfer(20'h0FFF5, 37, 0, 0, 0);
        check(got_done && !got_err, "R1 read done", got_done, 1);
        check(busy_seen, "R10 busy during transfer", busy_seen, 1);
        check(go_cnt == 3, "R1 piece count", go_cnt, 3);
        check(go_addr[0] == 20'h0FFF5 && go_addr[1] == 20'h10005 && go_addr[2] == 20'h10015,
              "R1 R3 piece addresses", int'(go_addr[2]), 'h10015);
        check(go_len[0] == 16 && go_len[1] == 16 && go_len[2] == 5, "R4 length field",
              go_len[2], 5);
        check(go_rd[0] && cmd_bad == 0 && seq_bad == 0, "R4 read command", cmd_bad, 0);
        check_read_bytes("R6 read stream", 20'h0FFF5, 37);
    endtask

    task automatic t_write_chunks();
        run_xfer(20'h00100, 20, 1, 0, 0);
        check(got_done, "R5 write done", got_done, 1);
        check(go_cnt == 2 && go_len[0] == 16 && go_len[1] == 4, "R1 write pieces", go_len[1], 4);
        check(!go_rd[0] && go_addr[1] == 20'h00110, "R4 write command", int'(go_addr[1]), 'h110);
        check(wbuf_bad == 0, "R5 write buffer bytes", wbuf_bad, 0);
        check(widx == 20, "R5 host bytes pulled", widx, 20);
        check(rcnt == 0, "R6 no read bytes on write", rcnt, 0);
    endtask

    task automatic t_retry_err_flag();
        run_xfer(20'h4_2300, 8, 0, 3, 0);
        check(got_done, "R9 error flag retried", got_done, 1);
        check(go_cnt == 4, "R9 attempts", go_cnt, 4);
        check(clr_cnt == 4 && seq_bad == 0, "R3 clear per attempt", clr_cnt, 4);
        check(go_addr[0] == go_addr[3], "R1 address held on retry", int'(go_addr[3]), int'(go_addr[0]));
        check_read_bytes("R6 copy after success", 20'h4_2300, 8);
    endtask

    task automatic t_status_write_retry();
        run_xfer(20'h0_0A00, 5, 1, 2, 1);
        check(got_done, "R9 status retried", got_done, 1);
        check(go_cnt == 3, "R9 status attempts", go_cnt, 3);
        check(widx == 5, "R5 no re-pull on retry", widx, 5);
        check(wbuf_bad == 0, "R5 reloaded buffer", wbuf_bad, 0);
    endtask

    task automatic t_reply_timeout();
        run_xfer(20'h0_0040, 4, 0, 1, 2);
        check(got_done && go_cnt == 2, "R8 reply timeout retried", go_cnt, 2);
        check_read_bytes("R8 read after timeout", 20'h0_0040, 4);
    endtask

    task automatic t_enable_timeout();
        run_xfer(20'h0_0080, 4, 0, 1, 3);
        check(got_done && go_cnt == 2, "R7 enable timeout retried", go_cnt, 2);
    endtask

    task automatic t_nine_failures();
        run_xfer(20'h0_0200, 3, 0, 9, 0);
        check(got_done && !got_err, "R2 ninth failure then success", got_done, 1);
        check(go_cnt == 10, "R2 attempts with nine failures", go_cnt, 10);
    endtask

    task automatic t_all_fail();
        run_xfer(20'h0_0300, 3, 0, 10, 0);
        check(got_err && !got_done, "R2 exhausted retries", got_err, 1);
        check(go_cnt == 10, "R2 attempt limit", go_cnt, 10);
        check(rcnt == 0, "R6 nothing on failure", rcnt, 0);
        repeat (30) @(negedge clk);
        check(!busy && go_cnt == 10, "R2 no attempt after error", go_cnt, 10);
    endtask

    task automatic t_zero_len();
        run_xfer(20'h0_0500, 0, 0, 0, 0);
        check(got_done && !busy_seen, "R11 zero length done", busy_seen, 0);
        check(go_cnt == 0 && clr_cnt == 0, "R11 no channel activity", go_cnt + clr_cnt, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_chunks();
        t_write_chunks();
        t_retry_err_flag();
        t_status_write_retry();
        t_reply_timeout();
        t_enable_timeout();
        t_nine_failures();
        t_all_fail();
        t_zero_len();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule